// File: doc/BRIEF.md
# DDR3 Power-Up Initialization Sequencer

This block sits on the controller side of a DDR3-class SDRAM link. It takes the memory from a cold, unpowered state to a usable state. The sequence starts when a power-good input is seen high. The block holds the device reset low for a programmed number of clocks, releases it, and then keeps the clock enable low for a second interval. It then raises the clock enable and waits a further exit interval. After that it writes the four mode registers in the order the device requires: register 2, register 3, register 1 and register 0. The last write is followed by a long ZQ calibration command. Once the calibration time has passed, the block raises a completion flag and the normal-traffic logic can take over the pins.

Every interval is a parameter counted in controller clock cycles. The values written to the mode registers come in on input ports, so the surrounding logic chooses burst, latency and termination settings. A drop of power-good at any moment abandons the sequence and puts the device back under reset. The next rise of power-good starts the whole sequence again.

Top module: `ddr3_init_seq`

## Requirements
- R1: While reset is active or `pwr_good` is low, the outputs become `mem_reset_n`=0, `mem_cke`=0, `init_done`=0 and deselect (`mem_cs_n`=1). After a falling `pwr_good` is sampled, these values take effect from the next clock.
- R2: `mem_reset_n` stays low for exactly `T_RST` cycles after the first clock edge that samples `pwr_good` high. `mem_cke` is never high while `mem_reset_n` is low.
- R3: `mem_cke` rises exactly `T_CKE` cycles after `mem_reset_n` rises.
- R4: The first mode-register write comes `T_XPR` cycles after `mem_cke` rises. The writes go to bank addresses 2, 3, 1 and 0 in that order. Each write carries the matching input value (`mr2_val`, `mr3_val`, `mr1_val`, `mr0_val`) on `mem_addr`.
- R5: Consecutive mode-register writes are exactly `T_MRD` cycles apart. The ZQ calibration command follows the register-0 write by exactly `T_MOD` cycles.
- R6: The command encodings on {`mem_cs_n`,`mem_ras_n`,`mem_cas_n`,`mem_we_n`} are: mode-register write = 0000; ZQ long calibration = 0110, with `mem_addr` bit 10 high, all other address bits 0 and `mem_ba`=0; no-operation = 0111; deselect has `mem_cs_n`=1. Every selected cycle other than the five commands above is a no-operation.
- R7: `init_done` rises exactly `T_ZQ` cycles after the ZQ command. It then stays high, with only no-operations issued, for as long as `pwr_good` stays high.
- R8: `mem_odt` is low at all times.
- R9: A fall of `pwr_good` part-way through the sequence, or after completion, aborts it. The next rise of `pwr_good` repeats the full sequence from the reset hold.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Controller clock |
| rst_n | input | 1 | Synchronous active-low reset |
| pwr_good | input | 1 | Supply stable; high starts the sequence, low aborts it |
| mr0_val | input | ROW_W | Value for mode register 0 |
| mr1_val | input | ROW_W | Value for mode register 1 |
| mr2_val | input | ROW_W | Value for mode register 2 |
| mr3_val | input | ROW_W | Value for mode register 3 |
| mem_reset_n | output | 1 | Device reset, active low |
| mem_cke | output | 1 | Device clock enable |
| mem_odt | output | 1 | On-die termination control, held low |
| mem_cs_n | output | 1 | Chip select, active low |
| mem_ras_n | output | 1 | Row strobe, active low |
| mem_cas_n | output | 1 | Column strobe, active low |
| mem_we_n | output | 1 | Write enable, active low |
| mem_ba | output | BA_W | Bank address, selects the mode register |
| mem_addr | output | ROW_W | Address bus, carries the register value |
| init_done | output | 1 | Initialization complete |

## Verification
The bench builds the block with short intervals: a reset hold of 8, a clock-enable delay of 6, an exit wait of 5, a register spacing of 4, a post-register-0 wait of 7 and a calibration wait of 10 cycles. Each value differs from the others, so a swapped or misloaded interval moves an event to a cycle that can be told apart. The short intervals also let the bench run several complete bring-ups, an abort during the register writes and an abort after completion within a few hundred cycles. Two runs use different register values, so a wrong value-to-bank pairing shows up on the address bus.

// File: rtl/ddr3_init_pkg.sv
// Package: shared types for the DDR3 init sequencer.
// Assumes: exactly four mode registers, written in a fixed order.
package ddr3_init_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_RST,
        ST_CKE,
        ST_XPR,
        ST_MR,
        ST_ZQ,
        ST_DONE
    } init_state_e;

    typedef enum logic [1:0] {
        CMD_DES,
        CMD_NOP,
        CMD_MRS,
        CMD_ZQCL
    } init_cmd_e;

    // Maps a write slot (0..3) to the mode register number the device
    // expects in that slot.
    function automatic logic [1:0] mr_for_slot(input logic [1:0] slot);
        case (slot)
            2'd0:    mr_for_slot = 2'd2;
            2'd1:    mr_for_slot = 2'd3;
            2'd2:    mr_for_slot = 2'd1;
            default: mr_for_slot = 2'd0;
        endcase
    endfunction

endpackage

// File: rtl/init_timer.sv
// Module: down-counting wait timer.
// A load of N makes zero_o go high on the N-th cycle after the load edge.
// Assumes: load_val >= 1 whenever load_i is high.
module init_timer #(
    parameter int CNT_W = 20
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load_i,
    input  logic [CNT_W-1:0] load_val_i,
    output logic             zero_o
);

    logic [CNT_W-1:0] cnt_q;

    // Load the count minus one, then count down to zero and hold there.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (load_i) begin
            cnt_q <= load_val_i - CNT_W'(1);
        end else if (cnt_q != '0) begin
            cnt_q <= cnt_q - CNT_W'(1);
        end
    end

    assign zero_o = (cnt_q == '0);

endmodule

// File: rtl/init_cmd_enc.sv
// Module: turns the sequencer's command request into pin levels.
// Assumes: ROW_W > 10, because the ZQ long command needs address bit 10.
module init_cmd_enc
    import ddr3_init_pkg::*;
#(
    parameter int ROW_W = 13,
    parameter int BA_W  = 3
) (
    input  init_cmd_e             cmd_i,
    input  logic [1:0]            mr_sel_i,
    input  logic [3:0][ROW_W-1:0] mr_vals_i,
    output logic                  cs_n_o,
    output logic                  ras_n_o,
    output logic                  cas_n_o,
    output logic                  we_n_o,
    output logic [BA_W-1:0]       ba_o,
    output logic [ROW_W-1:0]      addr_o
);

    localparam int ZQ_BIT = 10;

    // Select the strobe pattern, bank and address for the requested command.
    always_comb begin
        cs_n_o  = 1'b1;
        ras_n_o = 1'b1;
        cas_n_o = 1'b1;
        we_n_o  = 1'b1;
        ba_o    = '0;
        addr_o  = '0;
        case (cmd_i)
            CMD_NOP: begin
                cs_n_o = 1'b0;
            end
            CMD_MRS: begin
                cs_n_o  = 1'b0;
                ras_n_o = 1'b0;
                cas_n_o = 1'b0;
                we_n_o  = 1'b0;
                ba_o    = BA_W'(mr_sel_i);
                addr_o  = mr_vals_i[mr_sel_i];
            end
            CMD_ZQCL: begin
                cs_n_o         = 1'b0;
                we_n_o         = 1'b0;
                addr_o[ZQ_BIT] = 1'b1;
            end
            default: begin
            end
        endcase
    end

endmodule

// File: rtl/init_fsm.sv
// Module: bring-up state machine.
// Every state that waits loads the timer on entry. A mode-register or ZQ
// state issues its command in its first cycle only and then idles with
// no-operations until the timer reaches zero.
// Assumes: all interval parameters are >= 1.
module init_fsm
    import ddr3_init_pkg::*;
#(
    parameter int CNT_W  = 20,
    parameter int T_RST  = 160000,
    parameter int T_CKE  = 400000,
    parameter int T_XPR  = 216,
    parameter int T_MRD  = 4,
    parameter int T_MOD  = 12,
    parameter int T_ZQ   = 512
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             pwr_good,
    input  logic             zero_i,
    output logic             load_o,
    output logic [CNT_W-1:0] load_val_o,
    output init_state_e      state_o,
    output logic             first_o,
    output logic [1:0]       slot_o
);

    init_state_e state_q, state_d;
    logic [1:0]  slot_q, slot_d;
    logic        first_q;

    // Next-state, slot and timer-load decisions.
    always_comb begin
        state_d    = state_q;
        slot_d     = slot_q;
        load_o     = 1'b0;
        load_val_o = '0;
        if (!pwr_good) begin
            state_d = ST_IDLE;
        end else begin
            case (state_q)
                ST_IDLE: begin
                    state_d    = ST_RST;
                    load_o     = 1'b1;
                    load_val_o = CNT_W'(T_RST);
                end
                ST_RST: if (zero_i) begin
                    state_d    = ST_CKE;
                    load_o     = 1'b1;
                    load_val_o = CNT_W'(T_CKE);
                end
                ST_CKE: if (zero_i) begin
                    state_d    = ST_XPR;
                    load_o     = 1'b1;
                    load_val_o = CNT_W'(T_XPR);
                end
                ST_XPR: if (zero_i) begin
                    state_d    = ST_MR;
                    slot_d     = 2'd0;
                    load_o     = 1'b1;
                    load_val_o = CNT_W'(T_MRD);
                end
                ST_MR: if (zero_i) begin
                    load_o = 1'b1;
                    if (slot_q == 2'd3) begin
                        state_d    = ST_ZQ;
                        load_val_o = CNT_W'(T_ZQ);
                    end else begin
                        slot_d     = slot_q + 2'd1;
                        load_val_o = (slot_q == 2'd2) ? CNT_W'(T_MOD)
                                                      : CNT_W'(T_MRD);
                    end
                end
                ST_ZQ: if (zero_i) begin
                    state_d = ST_DONE;
                end
                default: begin
                end
            endcase
        end
    end

    // State, slot and first-cycle flag registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            slot_q  <= 2'd0;
            first_q <= 1'b0;
        end else begin
            state_q <= state_d;
            slot_q  <= slot_d;
            first_q <= load_o;
        end
    end

    assign state_o = state_q;
    assign first_o = first_q;
    assign slot_o  = slot_q;

endmodule

// File: rtl/ddr3_init_seq.sv
// Module: top of the DDR3 power-up initialization sequencer.
// Drives reset, clock enable, termination and the command pins from the
// first power-good cycle up to the completion flag.
// Assumes: power-good is synchronous to clk. Intervals are in clk cycles.
module ddr3_init_seq
    import ddr3_init_pkg::*;
#(
    parameter int ROW_W  = 13,
    parameter int BA_W   = 3,
    parameter int CNT_W  = 20,
    parameter int T_RST  = 160000,
    parameter int T_CKE  = 400000,
    parameter int T_XPR  = 216,
    parameter int T_MRD  = 4,
    parameter int T_MOD  = 12,
    parameter int T_ZQ   = 512
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             pwr_good,
    input  logic [ROW_W-1:0] mr0_val,
    input  logic [ROW_W-1:0] mr1_val,
    input  logic [ROW_W-1:0] mr2_val,
    input  logic [ROW_W-1:0] mr3_val,
    output logic             mem_reset_n,
    output logic             mem_cke,
    output logic             mem_odt,
    output logic             mem_cs_n,
    output logic             mem_ras_n,
    output logic             mem_cas_n,
    output logic             mem_we_n,
    output logic [BA_W-1:0]  mem_ba,
    output logic [ROW_W-1:0] mem_addr,
    output logic             init_done
);

    logic                  tmr_load;
    logic [CNT_W-1:0]      tmr_val;
    logic                  tmr_zero;
    init_state_e           state;
    logic                  first;
    logic [1:0]            slot;
    init_cmd_e             cmd;
    logic [3:0][ROW_W-1:0] mr_vals;

    assign mr_vals = {mr3_val, mr2_val, mr1_val, mr0_val};

    init_timer #(.CNT_W(CNT_W)) u_timer (
        .clk        (clk),
        .rst_n      (rst_n),
        .load_i     (tmr_load),
        .load_val_i (tmr_val),
        .zero_o     (tmr_zero)
    );

    init_fsm #(
        .CNT_W (CNT_W),
        .T_RST (T_RST),
        .T_CKE (T_CKE),
        .T_XPR (T_XPR),
        .T_MRD (T_MRD),
        .T_MOD (T_MOD),
        .T_ZQ  (T_ZQ)
    ) u_fsm (
        .clk        (clk),
        .rst_n      (rst_n),
        .pwr_good   (pwr_good),
        .zero_i     (tmr_zero),
        .load_o     (tmr_load),
        .load_val_o (tmr_val),
        .state_o    (state),
        .first_o    (first),
        .slot_o     (slot)
    );

    // Choose the command for this cycle from the state and first-cycle flag.
    always_comb begin
        case (state)
            ST_IDLE, ST_RST: cmd = CMD_DES;
            ST_MR:           cmd = first ? CMD_MRS  : CMD_NOP;
            ST_ZQ:           cmd = first ? CMD_ZQCL : CMD_NOP;
            default:         cmd = CMD_NOP;
        endcase
    end

    init_cmd_enc #(.ROW_W(ROW_W), .BA_W(BA_W)) u_enc (
        .cmd_i     (cmd),
        .mr_sel_i  (mr_for_slot(slot)),
        .mr_vals_i (mr_vals),
        .cs_n_o    (mem_cs_n),
        .ras_n_o   (mem_ras_n),
        .cas_n_o   (mem_cas_n),
        .we_n_o    (mem_we_n),
        .ba_o      (mem_ba),
        .addr_o    (mem_addr)
    );

    assign mem_reset_n = (state != ST_IDLE) && (state != ST_RST);
    assign mem_cke     = (state == ST_XPR) || (state == ST_MR) ||
                         (state == ST_ZQ)  || (state == ST_DONE);
    assign mem_odt     = 1'b0;
    assign init_done   = (state == ST_DONE);

endmodule

// File: rtl/ddr3_init_seq_chk.sv
// Module: protocol checker for ddr3_init_seq, attached with bind.
// Counts mode-register writes and the gaps between them to check order and
// spacing against the pins alone.
module ddr3_init_seq_chk #(
    parameter int ROW_W = 13,
    parameter int BA_W  = 3,
    parameter int T_MRD = 4
) (
    input logic             clk,
    input logic             rst_n,
    input logic             pwr_good,
    input logic             mem_reset_n,
    input logic             mem_cke,
    input logic             mem_odt,
    input logic             mem_cs_n,
    input logic             mem_ras_n,
    input logic             mem_cas_n,
    input logic             mem_we_n,
    input logic [BA_W-1:0]  mem_ba,
    input logic [ROW_W-1:0] mem_addr,
    input logic             init_done
);

    logic        is_mrs, is_zq;
    logic [2:0]  mrs_cnt_q;
    int unsigned gap_q;
    logic [1:0]  exp_ba;

    assign is_mrs = !mem_cs_n && !mem_ras_n && !mem_cas_n && !mem_we_n;
    assign is_zq  = !mem_cs_n && mem_ras_n && mem_cas_n && !mem_we_n;

    always_comb begin
        case (mrs_cnt_q)
            3'd0:    exp_ba = 2'd2;
            3'd1:    exp_ba = 2'd3;
            3'd2:    exp_ba = 2'd1;
            default: exp_ba = 2'd0;
        endcase
    end

    // Count writes since the last reset and the cycles since the last write.
    always_ff @(posedge clk) begin
        if (!rst_n || !mem_reset_n) begin
            mrs_cnt_q <= '0;
            gap_q     <= 0;
        end else begin
            if (is_mrs) begin
                mrs_cnt_q <= mrs_cnt_q + 3'd1;
                gap_q     <= 1;
            end else if (gap_q < 1000) begin
                gap_q <= gap_q + 1;
            end
        end
    end

    a_r1_abort_resets: assert property (@(posedge clk) disable iff (!rst_n)
        !pwr_good |=> (!mem_reset_n && !init_done && mem_cs_n));

    a_r2_cke_needs_reset: assert property (@(posedge clk) disable iff (!rst_n)
        !mem_reset_n |-> !mem_cke);

    a_r4_mrs_order: assert property (@(posedge clk) disable iff (!rst_n)
        is_mrs |-> (mrs_cnt_q < 3'd4 && mem_ba == BA_W'(exp_ba)));

    a_r5_mrs_spacing: assert property (@(posedge clk) disable iff (!rst_n)
        (is_mrs && mrs_cnt_q != 3'd0) |-> gap_q == T_MRD);

    a_r6_zq_addr: assert property (@(posedge clk) disable iff (!rst_n)
        is_zq |-> (mem_addr[10] && mrs_cnt_q == 3'd4));

    a_r6_legal_cmd: assert property (@(posedge clk) disable iff (!rst_n)
        !mem_cs_n |-> (is_mrs || is_zq || (mem_ras_n && mem_cas_n && mem_we_n)));

    a_r7_done_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        init_done |-> (mem_cke && mem_reset_n && !is_mrs && !is_zq));

    a_r8_odt_low: assert property (@(posedge clk) disable iff (!rst_n)
        !mem_odt);

endmodule

bind ddr3_init_seq ddr3_init_seq_chk #(
    .ROW_W (ROW_W),
    .BA_W  (BA_W),
    .T_MRD (T_MRD)
) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .pwr_good    (pwr_good),
    .mem_reset_n (mem_reset_n),
    .mem_cke     (mem_cke),
    .mem_odt     (mem_odt),
    .mem_cs_n    (mem_cs_n),
    .mem_ras_n   (mem_ras_n),
    .mem_cas_n   (mem_cas_n),
    .mem_we_n    (mem_we_n),
    .mem_ba      (mem_ba),
    .mem_addr    (mem_addr),
    .init_done   (init_done)
);

// File: tb/ddr3_init_seq_tb.sv
// Scoreboard bench: the driver pushes expected pin events with their cycle
// offsets; the monitor detects events at falling edges and compares.
module ddr3_init_seq_tb;

    localparam int ROW_W = 13;
    localparam int BA_W  = 3;
    localparam int T_RST = 8;
    localparam int T_CKE = 6;
    localparam int T_XPR = 5;
    localparam int T_MRD = 4;
    localparam int T_MOD = 7;
    localparam int T_ZQ  = 10;

    localparam int EV_RST  = 0;
    localparam int EV_CKE  = 1;
    localparam int EV_MRS  = 2;
    localparam int EV_ZQ   = 3;
    localparam int EV_DONE = 4;

    typedef struct {
        int kind;
        int t;
        int ba;
        int addr;
    } ev_t;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic             pwr_good = 1'b0;
    logic [ROW_W-1:0] mr0_val = '0, mr1_val = '0, mr2_val = '0, mr3_val = '0;
    logic             mem_reset_n, mem_cke, mem_odt;
    logic             mem_cs_n, mem_ras_n, mem_cas_n, mem_we_n;
    logic [BA_W-1:0]  mem_ba;
    logic [ROW_W-1:0] mem_addr;
    logic             init_done;

    int  checks = 0;
    int  errors = 0;
    int  rel = -1;
    bit  prev_rst = 0, prev_cke = 0, prev_done = 0;
    bit  finished = 0;
    ev_t exp_q[$];

    always #10 clk = ~clk;

    ddr3_init_seq #(
        .ROW_W (ROW_W), .BA_W (BA_W), .CNT_W (8),
        .T_RST (T_RST), .T_CKE (T_CKE), .T_XPR (T_XPR),
        .T_MRD (T_MRD), .T_MOD (T_MOD), .T_ZQ (T_ZQ)
    ) u_dut (
        .clk (clk), .rst_n (rst_n), .pwr_good (pwr_good),
        .mr0_val (mr0_val), .mr1_val (mr1_val),
        .mr2_val (mr2_val), .mr3_val (mr3_val),
        .mem_reset_n (mem_reset_n), .mem_cke (mem_cke), .mem_odt (mem_odt),
        .mem_cs_n (mem_cs_n), .mem_ras_n (mem_ras_n),
        .mem_cas_n (mem_cas_n), .mem_we_n (mem_we_n),
        .mem_ba (mem_ba), .mem_addr (mem_addr), .init_done (init_done)
    );

    task automatic check(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic push(input int kind, input int t, input int ba, input int addr);
        ev_t e;
        e.kind = kind; e.t = t; e.ba = ba; e.addr = addr;
        exp_q.push_back(e);
    endtask

    // Compare an observed event with the head of the expected queue.
    task automatic got(input int kind, input int ba, input int addr);
        ev_t e;
        if (exp_q.size() == 0) begin
            check(0, "R7 unexpected event", kind, -1);
        end else begin
            e = exp_q.pop_front();
            check(kind == e.kind, "R4 event kind/order", kind, e.kind);
            check(rel == e.t, "R2/R3/R5/R7 event cycle", rel, e.t);
            check(ba == e.ba, "R4 bank address", ba, e.ba);
            check(addr == e.addr, "R4/R6 address bus", addr, e.addr);
        end
    endtask

    // Monitor: sample away from the rising edge and detect pin events.
    always @(negedge clk) begin
        if (!rst_n) begin
            rel = -1;
            prev_rst = 0; prev_cke = 0; prev_done = 0;
        end else begin
            rel = pwr_good ? rel + 1 : -1;
            check(!mem_odt, "R8 odt low", int'(mem_odt), 0);
            if (!mem_reset_n)
                check(!mem_cke, "R2 cke low in reset", int'(mem_cke), 0);
            if (mem_reset_n && !prev_rst) got(EV_RST, 0, 0);
            if (mem_cke && !prev_cke) got(EV_CKE, 0, 0);
            if (!mem_cs_n && !mem_ras_n && !mem_cas_n && !mem_we_n)
                got(EV_MRS, int'(mem_ba), int'(mem_addr));
            else if (!mem_cs_n && mem_ras_n && mem_cas_n && !mem_we_n)
                got(EV_ZQ, int'(mem_ba), int'(mem_addr));
            else if (!mem_cs_n && !(mem_ras_n && mem_cas_n && mem_we_n))
                check(0, "R6 illegal command", {mem_ras_n, mem_cas_n, mem_we_n}, 7);
            if (init_done && !prev_done) got(EV_DONE, 0, 0);
            prev_rst  = mem_reset_n;
            prev_cke  = mem_cke;
            prev_done = init_done;
        end
    end

    // Driver: raise power-good and queue every expected event of one bring-up.
    task automatic start_init(input logic [ROW_W-1:0] v0, input logic [ROW_W-1:0] v1,
                              input logic [ROW_W-1:0] v2, input logic [ROW_W-1:0] v3);
        int base;
        @(negedge clk);
        #1;
        mr0_val = v0; mr1_val = v1; mr2_val = v2; mr3_val = v3;
        pwr_good = 1'b1;
        base = T_RST + T_CKE + T_XPR;
        push(EV_RST, T_RST, 0, 0);
        push(EV_CKE, T_RST + T_CKE, 0, 0);
        push(EV_MRS, base, 2, int'(v2));
        push(EV_MRS, base + T_MRD, 3, int'(v3));
        push(EV_MRS, base + 2 * T_MRD, 1, int'(v1));
        push(EV_MRS, base + 3 * T_MRD, 0, int'(v0));
        push(EV_ZQ, base + 3 * T_MRD + T_MOD, 0, 1 << 10);
        push(EV_DONE, base + 3 * T_MRD + T_MOD + T_ZQ, 0, 0);
    endtask

    task automatic drop_power();
        @(negedge clk);
        #1;
        pwr_good = 1'b0;
        exp_q.delete();
        @(negedge clk);
        #1;
        check(!mem_reset_n, "R9 reset after abort", int'(mem_reset_n), 0);
        check(!mem_cke, "R9 cke after abort", int'(mem_cke), 0);
        check(!init_done, "R9 done after abort", int'(init_done), 0);
        check(mem_cs_n, "R1 deselect after abort", int'(mem_cs_n), 1);
    endtask

    task automatic wait_done_and_hold();
        while (exp_q.size() != 0) @(negedge clk);
        repeat (6) begin
            @(negedge clk);
            #1;
            check(init_done, "R7 done holds", int'(init_done), 1);
        end
    endtask

    initial begin
        repeat (3) @(negedge clk);
        #1;
        check(!mem_reset_n && !mem_cke && mem_cs_n && !init_done,
              "R1 outputs in reset", {mem_reset_n, mem_cke, mem_cs_n, init_done}, 2);
        rst_n = 1'b1;
        repeat (4) @(negedge clk);
        #1;
        check(!mem_reset_n && !mem_cke && mem_cs_n && !init_done,
              "R1 idle without power-good", {mem_reset_n, mem_cke, mem_cs_n, init_done}, 2);

        start_init(13'h0A15, 13'h0044, 13'h0208, 13'h0003);
        wait_done_and_hold();

        drop_power();
        repeat (3) @(negedge clk);

        start_init(13'h1F0F, 13'h1234, 13'h0555, 13'h0AAA);
        while (exp_q.size() > 4) @(negedge clk);
        drop_power();
        repeat (2) @(negedge clk);

        start_init(13'h0101, 13'h0202, 13'h0404, 13'h0808);
        wait_done_and_hold();

        finished = 1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (5000) @(posedge clk);
        if (!finished) begin
            checks++;
            errors++;
            $display("FAIL watchdog: actual=timeout expected=completion");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

endmodule